// File: doc/BRIEF.md
# Two-Word Command Port Decoder

This block sits behind the 16-bit control port of a display controller. Each control word is either a one-word register write or one half of a two-word command. It keeps a 6-bit access code and a 16-bit access address, and it drives a write interface for the register file. It also keeps private copies of the three registers it depends on: the mode register (index 1), the address step register (index 15) and the transfer-type register (index 23). When a two-word command asks for a transfer and transfers are enabled, it issues a transfer start with the transfer kind.

Accesses to the data port do not carry an address of their own. The decoder turns each one into an access request that holds the current code and address, then advances the address by the programmed step. A status read, a data read or a data write drops a half-received command. The memory arrays and the transfer engine are outside this block. They see only the request and start pulses.

Two state machines are used. The command tracker has the states CMD_IDLE and CMD_HALF. CMD_IDLE goes to CMD_HALF on a first word. CMD_HALF goes back to CMD_IDLE on a second word, a data access or a status read. The fill launcher has the states FILL_IDLE and FILL_ARMED. FILL_IDLE goes to FILL_ARMED when a fill transfer is requested. FILL_ARMED goes back to FILL_IDLE on the next data write, or when another transfer request replaces the fill.

Top module: `cmd_port_decoder`

## Requirements
- R1: After reset, no command is pending, the code and address are 0, no fill is armed, and every pulse output is low.
- R2: A word taken while no command is pending, with bits 15:14 = 2'b10, is a register write. One cycle later `rf_we` pulses for exactly one cycle, with `rf_idx` = bits 12:8 and `rf_wdata` = bits 7:0. No command becomes pending.
- R3: An accepted register write clears code bits 1:0 and address bits 13:0. Code bits 5:2 and address bits 15:14 keep their values.
- R4: While bit 2 of register 1 is 0, a register write to an index above 10 has no effect. There is no `rf_we` pulse, the code and address are unchanged, and the step copy is unchanged, so the address step seen on later data accesses stays the same.
- R5: Any other word taken while no command is pending is a first word. It loads code bits 1:0 from bits 15:14 and address bits 13:0 from bits 13:0, keeps the remaining bits, and marks a command as pending.
- R6: A word taken while a command is pending is a second word, whatever its top bits are. It loads code bits 5:2 from bits 7:4 and address bits 15:14 from bits 1:0, and clears the pending mark. It never produces a register write.
- R7: A status read, a data-port read or a data-port write clears the pending mark.
- R8: Each data-port read or write produces one `acc_valid` pulse one cycle later. The pulse carries the address and code as they were before the access, and `acc_write` is 1 for a write. After the access the address is the old address plus the value of register 15, modulo 2^16.
- R9: A second word that leaves code bit 5 set, while bit 4 of register 1 is 1, requests a transfer of kind register23[7:6]. For kinds 0, 1 (external-memory transfer) and 3 (internal copy), `dma_start` pulses one cycle later with `dma_kind` equal to the kind. With bit 4 clear or code bit 5 clear, nothing starts.
- R10: A requested kind 2 (fill) sets `fill_armed` and does not pulse `dma_start`. The next data-port write pulses `dma_start` with `dma_kind` = 2 and clears `fill_armed`. A data read leaves the fill armed.
- R11: When strobes coincide, only one is acted on. The order of precedence is control word, then data write, then data read, then status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Control word present this cycle |
| ctl_word | input | 16 | Control word |
| dport_wr | input | 1 | Data-port write strobe |
| dport_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status read strobe |
| cmd_pending | output | 1 | First half of a command received |
| cur_code | output | 6 | Current access code |
| cur_addr | output | 16 | Current access address |
| rf_we | output | 1 | Register-file write pulse |
| rf_idx | output | 5 | Register index |
| rf_wdata | output | 8 | Register data |
| acc_valid | output | 1 | Data access request pulse |
| acc_write | output | 1 | Request is a write |
| acc_code | output | 6 | Code for the request |
| acc_addr | output | 16 | Address for the request |
| dma_start | output | 1 | Transfer start pulse |
| dma_kind | output | 2 | Transfer kind |
| fill_armed | output | 1 | Fill waits for the next data write |

## Verification
A wrong pending mark shows up on the very next control word. A register-write pattern is taken as a second half, or the reverse, so `rf_we`, `cur_code` and `cur_addr` differ one cycle after that word. A corrupt step copy or address only shows when a data access happens: the `acc_addr` of the following access is wrong. A stale mode or type copy shows at the next transfer request, as a missing or mis-kinded `dma_start`, or as `fill_armed` in the wrong state. A wrong fill state stays hidden until the next data write.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_HALF = 1'b1
    } cmd_state_e;

    typedef enum logic {
        FILL_IDLE  = 1'b0,
        FILL_ARMED = 1'b1
    } fill_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_REGW,
        EV_REGW_DROP,
        EV_FIRST,
        EV_SECOND,
        EV_DWR,
        EV_DRD,
        EV_STAT
    } port_event_e;

    localparam logic [1:0] KIND_FILL = 2'd2;

endpackage

// File: rtl/cpd_shadow_regs.sv
module cpd_shadow_regs #(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_CPY = 3,
    parameter int unsigned CPY_IDX [NUM_CPY] = '{1, 15, 23}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_CPY*DATA_W-1:0] copies
);

    genvar g;
    generate
        for (g = 0; g < NUM_CPY; g++) begin : g_copy
            logic [DATA_W-1:0] val_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(CPY_IDX[g]))) begin
                    val_q <= wr_data;
                end
            end
            assign copies[g*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

endmodule

// File: rtl/cpd_cmd_fsm.sv
module cpd_cmd_fsm
    import cpd_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned LIMIT_IDX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_valid,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic              dport_wr,
    input  logic              dport_rd,
    input  logic              stat_rd,
    input  logic              ext_mode,
    input  logic [DATA_W-1:0] step,
    output logic              pending,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [CODE_W-1:0] acc_code,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              regw_fire,
    output logic              kick,
    output logic              dwr_fire
);

    localparam int unsigned LOW_W    = WORD_W - 2;
    localparam int unsigned HIGH_W   = ADDR_W - LOW_W;
    localparam int unsigned UPCODE_W = CODE_W - 2;
    localparam logic [1:0]  REGW_TAG = 2'b10;

    cmd_state_e  state_q, state_d;
    port_event_e ev;
    logic [CODE_W-1:0] code_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  word_idx;

    assign word_idx = ctl_word[DATA_W +: IDX_W];

    always_comb begin
        ev = EV_NONE;
        if (ctl_valid) begin
            if (state_q == CMD_HALF) begin
                ev = EV_SECOND;
            end else if (ctl_word[WORD_W-1 -: 2] == REGW_TAG) begin
                if (!ext_mode && (word_idx > IDX_W'(LIMIT_IDX))) begin
                    ev = EV_REGW_DROP;
                end else begin
                    ev = EV_REGW;
                end
            end else begin
                ev = EV_FIRST;
            end
        end else if (dport_wr) begin
            ev = EV_DWR;
        end else if (dport_rd) begin
            ev = EV_DRD;
        end else if (stat_rd) begin
            ev = EV_STAT;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (ev == EV_FIRST) state_d = CMD_HALF;
            CMD_HALF: if (ev == EV_SECOND || ev == EV_DWR ||
                          ev == EV_DRD   || ev == EV_STAT) state_d = CMD_IDLE;
            default:  state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q    <= '0;
            addr_q    <= '0;
            rf_we     <= 1'b0;
            rf_idx    <= '0;
            rf_wdata  <= '0;
            acc_valid <= 1'b0;
            acc_write <= 1'b0;
            acc_code  <= '0;
            acc_addr  <= '0;
        end else begin
            rf_we     <= 1'b0;
            acc_valid <= 1'b0;
            unique case (ev)
                EV_REGW: begin
                    rf_we               <= 1'b1;
                    rf_idx              <= word_idx;
                    rf_wdata            <= ctl_word[DATA_W-1:0];
                    code_q[1:0]         <= 2'b00;
                    addr_q[LOW_W-1:0]   <= '0;
                end
                EV_FIRST: begin
                    code_q[1:0]         <= ctl_word[WORD_W-1 -: 2];
                    addr_q[LOW_W-1:0]   <= ctl_word[LOW_W-1:0];
                end
                EV_SECOND: begin
                    code_q[CODE_W-1:2]  <= ctl_word[4 +: UPCODE_W];
                    addr_q[ADDR_W-1:LOW_W] <= ctl_word[HIGH_W-1:0];
                end
                EV_DWR, EV_DRD: begin
                    acc_valid <= 1'b1;
                    acc_write <= (ev == EV_DWR);
                    acc_code  <= code_q;
                    acc_addr  <= addr_q;
                    addr_q    <= addr_q + ADDR_W'(step);
                end
                default: begin
                end
            endcase
        end
    end

    assign pending   = (state_q == CMD_HALF);
    assign code      = code_q;
    assign addr      = addr_q;
    assign regw_fire = (ev == EV_REGW);
    assign kick      = (ev == EV_SECOND) && ctl_word[4 + UPCODE_W - 1];
    assign dwr_fire  = (ev == EV_DWR);

endmodule

// File: rtl/cpd_fill_fsm.sv
module cpd_fill_fsm
    import cpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick,
    input  logic       dma_en,
    input  logic [1:0] kind_sel,
    input  logic       dwr_fire,
    output logic       dma_start,
    output logic [1:0] dma_kind,
    output logic       armed
);

    fill_state_e state_q, state_d;
    logic        request;

    assign request = kick && dma_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: begin
                if (request && kind_sel == KIND_FILL) state_d = FILL_ARMED;
            end
            FILL_ARMED: begin
                if (request) state_d = (kind_sel == KIND_FILL) ? FILL_ARMED : FILL_IDLE;
                else if (dwr_fire) state_d = FILL_IDLE;
            end
            default: state_d = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FILL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start <= 1'b0;
            dma_kind  <= 2'd0;
        end else begin
            dma_start <= 1'b0;
            if (request && kind_sel != KIND_FILL) begin
                dma_start <= 1'b1;
                dma_kind  <= kind_sel;
            end else if (!request && dwr_fire && state_q == FILL_ARMED) begin
                dma_start <= 1'b1;
                dma_kind  <= KIND_FILL;
            end
        end
    end

    assign armed = (state_q == FILL_ARMED);

endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned LIMIT_IDX = 10,
    parameter int unsigned MODE_IDX  = 1,
    parameter int unsigned STEP_IDX  = 15,
    parameter int unsigned TYPE_IDX  = 23,
    parameter int unsigned EXT_BIT   = 2,
    parameter int unsigned DMAEN_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_valid,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic              dport_wr,
    input  logic              dport_rd,
    input  logic              stat_rd,
    output logic              cmd_pending,
    output logic [CODE_W-1:0] cur_code,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [CODE_W-1:0] acc_code,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              dma_start,
    output logic [1:0]        dma_kind,
    output logic              fill_armed
);

    localparam int unsigned NUM_CPY = 3;
    localparam int unsigned CPY_IDX [NUM_CPY] = '{MODE_IDX, STEP_IDX, TYPE_IDX};

    logic [NUM_CPY*DATA_W-1:0] copies;
    logic [DATA_W-1:0] mode_val, step_val, type_val;
    logic regw_fire, kick, dwr_fire;

    assign mode_val = copies[0*DATA_W +: DATA_W];
    assign step_val = copies[1*DATA_W +: DATA_W];
    assign type_val = copies[2*DATA_W +: DATA_W];

    cpd_cmd_fsm #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
        .IDX_W(IDX_W), .DATA_W(DATA_W), .LIMIT_IDX(LIMIT_IDX)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_word(ctl_word),
        .dport_wr(dport_wr), .dport_rd(dport_rd), .stat_rd(stat_rd),
        .ext_mode(mode_val[EXT_BIT]), .step(step_val),
        .pending(cmd_pending), .code(cur_code), .addr(cur_addr),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_code(acc_code), .acc_addr(acc_addr),
        .regw_fire(regw_fire), .kick(kick), .dwr_fire(dwr_fire)
    );

    cpd_shadow_regs #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_CPY(NUM_CPY), .CPY_IDX(CPY_IDX)
    ) u_copy (
        .clk(clk), .rst_n(rst_n),
        .wr_en(regw_fire),
        .wr_idx(ctl_word[DATA_W +: IDX_W]),
        .wr_data(ctl_word[DATA_W-1:0]),
        .copies(copies)
    );

    cpd_fill_fsm u_fill (
        .clk(clk), .rst_n(rst_n),
        .kick(kick), .dma_en(mode_val[DMAEN_BIT]),
        .kind_sel(type_val[DATA_W-1 -: 2]),
        .dwr_fire(dwr_fire),
        .dma_start(dma_start), .dma_kind(dma_kind), .armed(fill_armed)
    );

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CODE_W = 6,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LOW_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_valid,
    input logic              dport_wr,
    input logic              dport_rd,
    input logic              stat_rd,
    input logic              cmd_pending,
    input logic [CODE_W-1:0] cur_code,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              rf_we,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] step_val,
    input logic              dma_start,
    input logic [1:0]        dma_kind,
    input logic              fill_armed
);

    assert_regw_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !cmd_pending);

    assert_regw_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (cur_code[1:0] == 2'b00) && (cur_addr[LOW_W-1:0] == '0));

    assert_pending_from_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_pending) |-> $past(ctl_valid));

    assert_second_no_regw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && ctl_valid) |=> !rf_we && !cmd_pending);

    assert_strobe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_valid && (dport_wr || dport_rd || stat_rd)) |=> !cmd_pending);

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> cur_addr == acc_addr + ADDR_W'(step_val));

    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    assert_fill_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start && dma_kind == 2'd2) |-> $fell(fill_armed));

endmodule

bind cmd_port_decoder cpd_checker #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .DATA_W(DATA_W), .LOW_W(WORD_W - 2)
) u_cpd_checker (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid),
    .dport_wr(dport_wr), .dport_rd(dport_rd), .stat_rd(stat_rd),
    .cmd_pending(cmd_pending), .cur_code(cur_code), .cur_addr(cur_addr),
    .rf_we(rf_we), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .step_val(step_val), .dma_start(dma_start), .dma_kind(dma_kind),
    .fill_armed(fill_armed)
);

// File: tb/tb_cmd_port_decoder.sv
`timescale 1ns/1ps
module tb_cmd_port_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_valid = 1'b0;
    logic [15:0] ctl_word = '0;
    logic dport_wr = 1'b0, dport_rd = 1'b0, stat_rd = 1'b0;
    logic cmd_pending, rf_we, acc_valid, acc_write, dma_start, fill_armed;
    logic [5:0] cur_code, acc_code;
    logic [15:0] cur_addr, acc_addr;
    logic [4:0] rf_idx;
    logic [7:0] rf_wdata;
    logic [1:0] dma_kind;

    always #2 clk = ~clk;

    cmd_port_decoder dut (
        .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
        .dport_wr(dport_wr), .dport_rd(dport_rd), .stat_rd(stat_rd),
        .cmd_pending(cmd_pending), .cur_code(cur_code), .cur_addr(cur_addr),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_code(acc_code),
        .acc_addr(acc_addr), .dma_start(dma_start), .dma_kind(dma_kind),
        .fill_armed(fill_armed)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference state, built from the requirements
    bit m_pend, m_arm;
    logic [5:0] m_code;
    logic [15:0] m_addr;
    logic [7:0] m_r1, m_r15, m_r23;
    bit e_we, e_acc, e_accw, e_start;
    logic [4:0] e_idx;
    logic [7:0] e_wd;
    logic [5:0] e_acode;
    logic [15:0] e_aaddr;
    logic [1:0] e_kind, k_last;
    string m_tag;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_pend = 0; m_arm = 0; m_code = '0; m_addr = '0;
        m_r1 = '0; m_r15 = '0; m_r23 = '0;
        e_we = 0; e_acc = 0; e_accw = 0; e_start = 0;
        e_idx = '0; e_wd = '0; e_acode = '0; e_aaddr = '0; e_kind = '0;
    endfunction

    function automatic void model_step(bit cv, logic [15:0] w, bit dw, bit dr, bit st);
        e_we = 0; e_acc = 0; e_start = 0;
        m_tag = "R11";
        if (cv) begin
            if (m_pend) begin
                m_code[5:2] = w[7:4];
                m_addr[15:14] = w[1:0];
                m_pend = 0;
                m_tag = "R6";
                if (m_code[5] && m_r1[4]) begin
                    k_last = m_r23[7:6];
                    if (k_last == 2'd2) begin
                        m_arm = 1; m_tag = "R10";
                    end else begin
                        m_arm = 0; e_start = 1; e_kind = k_last; m_tag = "R9";
                    end
                end
            end else if (w[15:14] == 2'b10) begin
                if (!m_r1[2] && w[12:8] > 5'd10) begin
                    m_tag = "R4";
                end else begin
                    e_we = 1; e_idx = w[12:8]; e_wd = w[7:0];
                    if (w[12:8] == 5'd1)  m_r1  = w[7:0];
                    if (w[12:8] == 5'd15) m_r15 = w[7:0];
                    if (w[12:8] == 5'd23) m_r23 = w[7:0];
                    m_code[1:0] = 2'b00;
                    m_addr[13:0] = '0;
                    m_tag = "R2";
                end
            end else begin
                m_code[1:0] = w[15:14];
                m_addr[13:0] = w[13:0];
                m_pend = 1;
                m_tag = "R5";
            end
        end else if (dw || dr) begin
            e_acc = 1; e_accw = dw; e_acode = m_code; e_aaddr = m_addr;
            m_addr = m_addr + {8'h00, m_r15};
            m_pend = 0;
            m_tag = "R8";
            if (dw && m_arm) begin
                m_arm = 0; e_start = 1; e_kind = 2'd2; m_tag = "R10";
            end
        end else if (st) begin
            m_pend = 0;
            m_tag = "R7";
        end
    endfunction

    task automatic compare(string tag);
        chk(tag, "pending", cmd_pending, m_pend);
        chk(tag, "code", cur_code, m_code);
        chk(tag, "addr", cur_addr, m_addr);
        chk(tag, "rf_we", rf_we, e_we);
        if (e_we) begin
            chk(tag, "rf_idx", rf_idx, e_idx);
            chk(tag, "rf_wdata", rf_wdata, e_wd);
        end
        chk(tag, "acc_valid", acc_valid, e_acc);
        if (e_acc) begin
            chk(tag, "acc_write", acc_write, e_accw);
            chk(tag, "acc_code", acc_code, e_acode);
            chk(tag, "acc_addr", acc_addr, e_aaddr);
        end
        chk(tag, "dma_start", dma_start, e_start);
        if (e_start) chk(tag, "dma_kind", dma_kind, e_kind);
        chk(tag, "fill_armed", fill_armed, m_arm);
    endtask

    // drive one cycle at the falling edge, check at the next falling edge
    task automatic op(bit cv, logic [15:0] w, bit dw, bit dr, bit st, string tag = "");
        ctl_valid = cv; ctl_word = w; dport_wr = dw; dport_rd = dr; stat_rd = st;
        model_step(cv, w, dw, dr, st);
        @(negedge clk);
        ctl_valid = 0; dport_wr = 0; dport_rd = 0; stat_rd = 0;
        compare(tag == "" ? m_tag : tag);
    endtask

    task automatic ctl(logic [15:0] w, string tag = "");
        op(1, w, 0, 0, 0, tag);
    endtask

    function automatic logic [15:0] regw(logic [4:0] idx, logic [7:0] d);
        return {3'b100, idx, d};
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1");

        // R4: step register blocked while mode bit 2 is clear
        ctl(regw(5'd15, 8'h04), "R4");
        ctl(16'h0123, "R5");
        op(0, 0, 0, 1, 0, "R4");           // address must not move
        chk("R4", "addr unchanged", cur_addr, 16'h0123);

        // R2: enable extended indices and transfers, then set the step
        ctl(regw(5'd1, 8'h14), "R2");
        ctl(regw(5'd15, 8'h02), "R2");

        // R5 / R6 / R8
        ctl(16'h4ABC, "R5");
        ctl(16'h0062, "R6");
        op(0, 0, 1, 0, 0, "R8");
        op(0, 0, 0, 1, 0, "R8");

        // R3: register write keeps upper code and address bits
        ctl(16'h7FFF, "R5");
        ctl(16'h0073, "R6");
        ctl(regw(5'd7, 8'h55), "R3");
        chk("R3", "upper code kept", cur_code, 6'h1C);
        chk("R3", "upper addr kept", cur_addr, 16'hC000);

        // R7: status read and data read drop a half command
        ctl(16'h1111, "R5");
        op(0, 0, 0, 0, 1, "R7");
        ctl(16'h2222, "R5");
        op(0, 0, 0, 1, 0, "R7");
        ctl(16'h3333, "R5");
        op(0, 0, 1, 0, 0, "R7");

        // R9: each non-fill kind, then with transfers disabled
        for (int k = 0; k < 4; k++) begin
            if (k == 2) continue;
            ctl(regw(5'd23, 8'(k << 6)), "R9");
            ctl(16'h4000, "R9");
            ctl(16'h0080, "R9");
        end
        ctl(regw(5'd1, 8'h04), "R9");
        ctl(16'h4000, "R9");
        ctl(16'h0080, "R9");
        chk("R9", "no start when disabled", dma_start, 1'b0);
        ctl(regw(5'd1, 8'h14), "R9");
        ctl(16'h4000, "R9");
        ctl(16'h0010, "R9");               // code bit 5 clear

        // R10: fill arms, a read leaves it, a write fires it
        ctl(regw(5'd23, 8'h80), "R10");
        ctl(16'h4010, "R10");
        ctl(16'h0080, "R10");
        op(0, 0, 0, 1, 0, "R10");
        op(0, 0, 1, 0, 0, "R10");

        // R8: wrap at 16 bits
        ctl(16'h7FFF, "R8");
        ctl(16'h0003, "R8");
        op(0, 0, 0, 1, 0, "R8");
        chk("R8", "wrapped addr", cur_addr, 16'h0001);

        // R11: coinciding strobes
        ctl(16'h0100, "R11");
        op(1, 16'h0000, 1, 1, 1, "R11");
        op(0, 0, 1, 1, 1, "R11");
        op(0, 0, 0, 1, 1, "R11");

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [15:0] w;
            sel = $urandom_range(0, 99);
            w = 16'($urandom);
            if (sel < 25) begin
                w[15:14] = 2'b10;
                if ($urandom_range(0, 3) == 0) w[12:8] = 5'd1;
                else if ($urandom_range(0, 3) == 0) w[12:8] = 5'd23;
                else if ($urandom_range(0, 3) == 0) w[12:8] = 5'd15;
                ctl(w);
            end else if (sel < 55) begin
                ctl(w);
            end else if (sel < 70) begin
                op(0, 0, 1, 0, 0);
            end else if (sel < 82) begin
                op(0, 0, 0, 1, 0);
            end else if (sel < 92) begin
                op(0, 0, 0, 0, 1);
            end else begin
                op(1'($urandom), w, 1'($urandom), 1'($urandom), 1'($urandom));
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule